// File: doc/BRIEF.md
# Flash Mode and Erase-Block Control Registers

This block holds the two control registers that gate program and erase sequencing of an on-chip flash controller. A mode register carries seven control bits: a software enable, program setup, erase setup, program verify, erase verify, program and erase. A block-select register carries one bit per flash block and names the single block an erase may touch. A simple CPU bus writes either register in one cycle and reads the addressed register back combinationally.

Writes are not taken at face value. The level of a hardware write-enable pin, a standby indication and the software enable bit decide whether a write is stored, ignored or rejected. Some states force register contents to zero. A write that would set more than one mode bit at once, that sets program setup without the required enables, that sets program without a prior setup, or that names more than one block is refused, and a one-cycle reject pulse reports it. The erase-enable output to the array rises only when the erase bit is set and exactly one block is selected. Pulse timing and the array itself lie outside this block.

The asynchronous active-low reset is released through a two-stage synchronizer. Register contents therefore leave reset two clock edges after the reset input rises.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `reject_o` is low and `erase_en_o` is low.
- R2: Program setup (mode bit 1) can become 1 only if, at that clock edge, `hw_wen_i` is high and software enable (mode bit 0) is already 1. Otherwise the write is refused and the register keeps its value.
- R3: The mode register is selected with `bus_sel_i`=0. Its bits are: bit 0 software enable, bit 1 program setup, bit 2 erase setup, bit 3 program verify, bit 4 erase verify, bit 5 program, bit 6 erase. Bit 7 reads 0. A write that turns more than one bit from 0 to 1 is refused whole, and the register keeps its value. Clearing bits in the same write as setting one bit is allowed.
- R4: Program (mode bit 5) can become 1 only while program setup (bit 1) is already 1. Otherwise the write is refused.
- R5: At any clock edge where `hw_wen_i` is low or `standby_i` is high, mode bits 6..1 are cleared. Bit 0 follows the normal write rules.
- R6: The block-select register is selected with `bus_sel_i`=1. Bits 6..0 each select one block, and bit 7 always reads 0. A permitted write whose bits 6..0 hold zero or one set bit is stored.
- R7: The block-select register becomes 0x00 at any edge where `hw_wen_i` is low, `standby_i` is high, or software enable is 0 after that edge. This includes the same edge that writes software enable to 0. Writes in those cycles are ignored and are not refused.
- R8: A permitted block-select write with two or more of bits 6..0 set is discarded, and the previous value is kept.
- R9: `reject_o` is high for exactly the one cycle following the clock edge of each refused write (R2, R3, R4, R8), and low otherwise.
- R10: `erase_en_o` is high exactly when mode bit 6 is 1 and exactly one block-select bit is 1.
- R11: `bus_rdata_o` shows the register addressed by `bus_sel_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_sel_i | input | 1 | 0 selects mode register, 1 selects block-select register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| hw_wen_i | input | 1 | Hardware write-enable pin level |
| standby_i | input | 1 | Standby indication |
| mode_o | output | 8 | Mode register contents |
| blk_o | output | 8 | Block-select register contents |
| erase_en_o | output | 1 | Erase enable to the array |
| reject_o | output | 1 | One-cycle pulse after a refused write |

## Verification
Every 8-bit mode write value is applied from four starting states.
- Cleared register: shows the multi-set refusal and that program setup is not accepted without software enable.
- Software enable set: shows which single bits are accepted, and that program is refused without setup.
- Software enable plus setup: shows that program is then accepted.
- Software enable set with standby asserted during the write: shows the forced clearing.

Every block-select value is written with the gate open and with the erase bit both clear and set. This separates zero, one-hot and multi-bit values, and shows the erase output following a lone selection. Lowering the pin, entering standby and clearing software enable each show the forced zero and the silent discard of writes made meanwhile.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int unsigned MODE_W     = 7;
  localparam int unsigned BIT_SWEN   = 0;
  localparam int unsigned BIT_PSETUP = 1;
  localparam int unsigned BIT_ESETUP = 2;
  localparam int unsigned BIT_PVFY   = 3;
  localparam int unsigned BIT_EVFY   = 4;
  localparam int unsigned BIT_PROG   = 5;
  localparam int unsigned BIT_ERASE  = 6;

  typedef enum logic {
    SEL_MODE  = 1'b0,
    SEL_BLOCK = 1'b1
  } bus_sel_e;
endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fc_mode_reg.sv
module fc_mode_reg
  import flash_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] wdata_i,
  input  logic              hw_wen_i,
  input  logic              standby_i,
  output logic [MODE_W-1:0] mode_q_o,
  output logic [MODE_W-1:0] mode_d_o,
  output logic              reject_o
);
  localparam logic [MODE_W-1:0] KEEP_MASK = MODE_W'(1) << BIT_SWEN;

  logic [MODE_W-1:0] mode_q, mode_d, newly_set;
  logic              multi_set, gate_fail, reject, force_clear, mode_en;

  // next-state
  always_comb begin
    newly_set   = wdata_i & ~mode_q;
    multi_set   = ($countones(newly_set) > 1);
    gate_fail   = (newly_set[BIT_PSETUP] & ~(hw_wen_i & mode_q[BIT_SWEN]))
                | (newly_set[BIT_PROG]   & ~mode_q[BIT_PSETUP]);
    reject      = wr_i & (multi_set | gate_fail);
    force_clear = ~hw_wen_i | standby_i;
    mode_d      = mode_q;
    if (wr_i && !reject) mode_d = wdata_i;
    if (force_clear)     mode_d = mode_d & KEEP_MASK;
    mode_en     = wr_i | force_clear;
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_q_o = mode_q;
  assign mode_d_o = mode_d;
  assign reject_o = reject;

  a_r2_psetup_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[BIT_PSETUP]) |-> $past(hw_wen_i && mode_q[BIT_SWEN]));

  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ($countones(mode_q & ~$past(mode_q)) <= 1));

  a_r3_multi_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ($countones(wdata_i & ~mode_q) > 1) && hw_wen_i && !standby_i)
      |=> (mode_q == $past(mode_q)));

  a_r4_prog_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[BIT_PROG]) |-> $past(mode_q[BIT_PSETUP]));

  a_r5_clear_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_wen_i || standby_i) |=> ((mode_q & ~KEEP_MASK) == '0));
endmodule

// File: rtl/fc_blk_sel.sv
module fc_blk_sel #(
  parameter int unsigned NB = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NB-1:0] wdata_i,
  input  logic          hold_i,
  output logic [NB-1:0] blk_q_o,
  output logic          single_o,
  output logic          reject_o
);
  logic [NB-1:0] blk_q, blk_d;
  logic          legal, accept, reject, blk_en;
  logic [NB:0]   seen, dup;

  // one-hot detector as a prefix chain
  assign seen[0] = 1'b0;
  assign dup[0]  = 1'b0;
  for (genvar i = 0; i < NB; i++) begin : g_chain
    assign seen[i+1] = seen[i] | blk_q[i];
    assign dup[i+1]  = dup[i]  | (seen[i] & blk_q[i]);
  end
  assign single_o = seen[NB] & ~dup[NB];

  // next-state
  always_comb begin
    legal  = ($countones(wdata_i) <= 1);
    accept = wr_i & ~hold_i &  legal;
    reject = wr_i & ~hold_i & ~legal;
    blk_d  = blk_q;
    if (hold_i)      blk_d = '0;
    else if (accept) blk_d = wdata_i;
    blk_en = hold_i | accept;
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blk_q <= '0;
    else if (blk_en) blk_q <= blk_d;
  end

  assign blk_q_o  = blk_q;
  assign reject_o = reject;

  a_r7_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (blk_q == '0));

  a_r8_at_most_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(blk_q));

  a_r8_bad_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hold_i && ($countones(wdata_i) > 1)) |=> $stable(blk_q));
endmodule

// File: rtl/fc_err_pulse.sv
module fc_err_pulse #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic         pulse_o
);
  logic pulse_q, pulse_d;

  always_comb pulse_d = |src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 7,
  parameter int unsigned BUS_W      = 8
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_sel_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic             hw_wen_i,
  input  logic             standby_i,
  output logic [BUS_W-1:0] mode_o,
  output logic [BUS_W-1:0] blk_o,
  output logic             erase_en_o,
  output logic             reject_o
);
  localparam int unsigned MODE_PAD = BUS_W - MODE_W;
  localparam int unsigned BLK_PAD  = BUS_W - NUM_BLOCKS;

  logic                  rst_n;
  logic                  wr_mode, wr_blk, blk_hold, blk_single;
  logic                  mode_rej, blk_rej;
  logic [MODE_W-1:0]     mode_q, mode_d;
  logic [NUM_BLOCKS-1:0] blk_q;
  logic                  unused_wdata;

  fc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .arst_ni(arst_ni), .rst_no(rst_n)
  );

  always_comb begin
    wr_mode  = bus_wr_i & (bus_sel_i == SEL_MODE);
    wr_blk   = bus_wr_i & (bus_sel_i == SEL_BLOCK);
    blk_hold = ~hw_wen_i | standby_i | ~mode_d[BIT_SWEN];
  end

  fc_mode_reg u_mode (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(wr_mode),
    .wdata_i(bus_wdata_i[MODE_W-1:0]), .hw_wen_i(hw_wen_i),
    .standby_i(standby_i), .mode_q_o(mode_q), .mode_d_o(mode_d),
    .reject_o(mode_rej)
  );

  fc_blk_sel #(.NB(NUM_BLOCKS)) u_blk (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(wr_blk),
    .wdata_i(bus_wdata_i[NUM_BLOCKS-1:0]), .hold_i(blk_hold),
    .blk_q_o(blk_q), .single_o(blk_single), .reject_o(blk_rej)
  );

  fc_err_pulse #(.N(2)) u_err (
    .clk_i(clk_i), .rst_ni(rst_n), .src_i({blk_rej, mode_rej}),
    .pulse_o(reject_o)
  );

  assign mode_o       = {{MODE_PAD{1'b0}}, mode_q};
  assign blk_o        = {{BLK_PAD{1'b0}}, blk_q};
  assign erase_en_o   = mode_q[BIT_ERASE] & blk_single;
  assign bus_rdata_o  = (bus_sel_i == SEL_BLOCK) ? blk_o : mode_o;
  assign unused_wdata = ^bus_wdata_i[BUS_W-1:MODE_W];

  a_r9_pulse_after_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    reject_o |-> $past(bus_wr_i));

  a_r10_erase_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    erase_en_o |-> ($onehot(blk_o) && mode_o[BIT_SWEN]));

  a_r7_swen_guard: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mode_o[BIT_SWEN] |-> (blk_o == '0));
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       arst_n, bus_wr, bus_sel, hw_wen, standby;
  logic [7:0] wdata, rdata, mode, blk;
  logic       erase_en, reject;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [6:0] em, eb;
  logic       ee;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_ctrl u0 (
    .clk_i(clk), .arst_ni(arst_n), .bus_wr_i(bus_wr), .bus_sel_i(bus_sel),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .hw_wen_i(hw_wen),
    .standby_i(standby), .mode_o(mode), .blk_o(blk),
    .erase_en_o(erase_en), .reject_o(reject)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "mode", mode, {1'b0, em});
    chk(tag, "blk", blk, {1'b0, eb});
    chk({tag, "/R9"}, "reject", {7'd0, reject}, {7'd0, ee});
    chk({tag, "/R10"}, "erase_en", {7'd0, erase_en},
        {7'd0, em[6] && ($countones(eb) == 1)});
    bus_sel = 1'b0; #1;
    chk({tag, "/R11"}, "rdata mode", rdata, {1'b0, em});
    bus_sel = 1'b1; #1;
    chk({tag, "/R11"}, "rdata blk", rdata, {1'b0, eb});
  endtask

  // Expected-state update for one clock edge, from the requirements.
  task automatic model_edge(input logic w, input logic a, input logic [7:0] d);
    logic [6:0] ns;
    logic       rej;
    logic       hold;
    rej = 1'b0;
    if (w && !a) begin
      ns  = d[6:0] & ~em;
      rej = ($countones(ns) > 1)
          || (ns[1] && !(hw_wen && em[0]))
          || (ns[5] && !em[1]);
      if (!rej) em = d[6:0];
    end
    if (!hw_wen || standby) em = em & 7'h01;
    hold = !hw_wen || standby || !em[0];
    if (hold) eb = 7'h00;
    else if (w && a) begin
      if ($countones(d[6:0]) <= 1) eb = d[6:0];
      else rej = 1'b1;
    end
    ee = rej;
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string tag);
    bus_wr = 1'b1; bus_sel = a; wdata = d;
    model_edge(1'b1, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    model_edge(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    arst_n = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0; wdata = '0;
    hw_wen = 1'b1; standby = 1'b0;
    em = '0; eb = '0; ee = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // Mode sweep from four starting states (R2 R3 R4 R5)
    for (int base = 0; base < 4; base++) begin
      for (int v = 0; v < 256; v++) begin
        wr(1'b0, 8'h00, "R3");
        if (base != 0) wr(1'b0, 8'h01, "R3");
        if (base == 2) wr(1'b0, 8'h03, "R2");
        if (base == 3) standby = 1'b1;
        wr(1'b0, 8'(v), base == 3 ? "R5" : (base == 2 ? "R4" : "R2/R3"));
        standby = 1'b0;
      end
    end

    // Program setup with the pin low is refused (R2)
    wr(1'b0, 8'h00, "R2");
    wr(1'b0, 8'h01, "R2");
    hw_wen = 1'b0;
    wr(1'b0, 8'h03, "R2");
    hw_wen = 1'b1;
    idle("R2");

    // Drop of pin clears setup/program bits (R5)
    wr(1'b0, 8'h03, "R5");
    wr(1'b0, 8'h23, "R4");
    hw_wen = 1'b0;
    idle("R5");
    hw_wen = 1'b1;
    idle("R5");

    // Block sweep, erase bit clear then set (R6 R8 R10)
    for (int pass = 0; pass < 2; pass++) begin
      wr(1'b0, 8'h00, "R6");
      wr(1'b0, 8'h01, "R6");
      if (pass == 1) wr(1'b0, 8'h41, "R10");
      for (int v = 0; v < 256; v++) begin
        wr(1'b1, 8'(v), pass == 1 ? "R10" : "R6/R8");
        idle("R9");
      end
    end

    // Hold conditions (R7)
    wr(1'b1, 8'h10, "R7");
    hw_wen = 1'b0;
    idle("R7");
    wr(1'b1, 8'h04, "R7");
    hw_wen = 1'b1;
    wr(1'b1, 8'h04, "R7");
    standby = 1'b1;
    idle("R7");
    wr(1'b1, 8'h02, "R7");
    standby = 1'b0;
    wr(1'b0, 8'h01, "R7");
    wr(1'b1, 8'h02, "R7");
    wr(1'b0, 8'h00, "R7");
    wr(1'b1, 8'h01, "R7");
    wr(1'b1, 8'h03, "R7");
    idle("R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule